// File: doc/BRIEF.md
# Double-Buffered DMA Pointer and Interrupt Unit

This unit keeps the ping-pong buffer pointers for one input and one output audio stream and the six interrupt flags that go with them. For each direction software loads a next-pointer register; when the serial side reports that the current buffer is finished, the unit moves the next pointer into the current pointer, clears the next register and raises that direction's done flag, asking software for the pointer after it. While a direction runs, every bus access it reports moves the current pointer forward by the size of the access. If the next pointer has not been refilled when a buffer ends, the unit raises the pointer-error flag and stops that direction.

Each direction runs one state machine with four states. OFF: the unit is disabled. WAIT_NEXT: running, with the next slot already consumed. READY: running, with a fresh next pointer loaded. HALT: stopped after a pointer underrun. The transitions are as follows:
- A nonzero buffer-length write (init) goes from any state to WAIT_NEXT, or to READY if a next-pointer write arrives in the same cycle.
- A zero buffer-length write (stop) goes from any state to OFF.
- A next-pointer write moves WAIT_NEXT to READY.
- Buffer end in READY is a handover. It goes to WAIT_NEXT, or stays in READY if a write arrives in the same cycle.
- Buffer end in WAIT_NEXT is an underrun and goes to HALT.
- HALT is left only by init or stop.

The flags have hardware set sources, software set and write-1 clear strobes and a mask. A single interrupt output is raised while any unmasked flag is set. The bus master, the memory and the serial engine are stood in for by strobes.

Top module: `aud_dma_ptr_unit`

## Requirements
- R1: After reset all flags, the mask, both current and next pointers, `buf_len`, `unit_en`, both active outputs and `irq_out` are zero.
- R2: A nonzero `cfg_len_wdata` write stores the length, sets `unit_en` and, for each direction, copies the next pointer into the current pointer, clears the next pointer and makes the direction active, without setting any flag. A zero write clears both current pointers and both active outputs and leaves all flags unchanged. While the unit is off, buffer ends and accesses do nothing.
- R3: A next pointer reads back its written value until a buffer end. At a buffer end with the pointer loaded, the current pointer takes that value, the next pointer reads zero and the done flag is set. The done flag is bit 5 for input and bit 4 for output.
- R4: In the following case the pointer-error flag (bit 0) is set and the direction goes inactive: a buffer end arrives while the direction has not had its next pointer rewritten since the last handover, including a rewrite that arrives in that same cycle. In that state accesses, buffer ends and late strobes have no effect and the current pointer is frozen.
- R5: While a direction is active, an access with `*_acc_half`=0 adds 1 to its current pointer and one with `*_acc_half`=1 adds 2. A buffer end in the same cycle drops the access.
- R6: Writing a next pointer clears its done flag in the next cycle. This clear wins over a software set and over a handover set that arrive in the same cycle. If a buffer end in READY coincides with a write, the old next pointer is handed over, the written value becomes the next pointer and the done flag stays clear.
- R7: The three event strobes set their flags: `wclk_timeout_evt` sets bit 3, `wclk_err_evt` sets bit 1, and a late strobe on an active direction sets bit 2. Bits 3 to 0 stay set until a software clear.
- R8: Writing 1 to a bit through `irq_set_*` sets that bit, and writing 1 through `irq_clr_*` clears it. A clear wins over a software set in the same cycle. A clear is ignored when a hardware set of that bit arrives in the same cycle. Bits written as 0 are unaffected.
- R9: `irq_out` is high exactly when some bit of `irq_flags` AND the mask register (written with `irq_mask_we`) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_we | input | 1 | Buffer-length write strobe |
| cfg_len_wdata | input | LW | Buffer length; nonzero enables and initialises, zero disables |
| in_nxt_we | input | 1 | Input next-pointer write strobe |
| in_nxt_wdata | input | AW | Input next-pointer value |
| out_nxt_we | input | 1 | Output next-pointer write strobe |
| out_nxt_wdata | input | AW | Output next-pointer value |
| in_acc_valid | input | 1 | Input-direction bus access done |
| in_acc_half | input | 1 | Input access size: 0 byte, 1 halfword |
| in_buf_end | input | 1 | Input buffer finished |
| in_acc_late | input | 1 | Input access not completed in time (overflow) |
| out_acc_valid | input | 1 | Output-direction bus access done |
| out_acc_half | input | 1 | Output access size: 0 byte, 1 halfword |
| out_buf_end | input | 1 | Output buffer finished |
| out_acc_late | input | 1 | Output access not completed in time (underflow) |
| wclk_timeout_evt | input | 1 | Word-clock timeout event |
| wclk_err_evt | input | 1 | Word-clock framing error event |
| irq_mask_we | input | 1 | Mask write strobe |
| irq_mask_wdata | input | 6 | Mask value |
| irq_set_we | input | 1 | Software set strobe |
| irq_set_wdata | input | 6 | Bits to set (1 = set) |
| irq_clr_we | input | 1 | Software clear strobe |
| irq_clr_wdata | input | 6 | Bits to clear (1 = clear) |
| buf_len | output | LW | Stored buffer length |
| unit_en | output | 1 | Unit enabled (length nonzero) |
| in_nxt_rd | output | AW | Input next-pointer read-back |
| in_cur | output | AW | Input current pointer |
| in_active | output | 1 | Input direction running |
| out_nxt_rd | output | AW | Output next-pointer read-back |
| out_cur | output | AW | Output current pointer |
| out_active | output | 1 | Output direction running |
| irq_flags | output | 6 | Raw flags |
| irq_out | output | 1 | Combined masked interrupt |

## Verification
Flag updates are where functions meet in one cycle: a hardware event, a software set and a software write-1 clear can all hit the same bit. The bench drives every combination of the three, for both starting values of two event flags. It compares each result with a priority rule computed in the bench, and repeats the clear-versus-event case on the bus-error flag. The done flags have a second meeting point, where a next-pointer write coincides with a software set or with a buffer-end handover. Buffer end also meets pointer refill: it is provoked with the write in the same cycle from both WAIT_NEXT and READY, and judged by the pointer values, the active outputs and the done and pointer-error flags.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;

    // Flag positions: software decodes these bits.
    localparam int NFLAG      = 6;
    localparam int F_IN_DONE  = 5;
    localparam int F_OUT_DONE = 4;
    localparam int F_WCLK_TO  = 3;
    localparam int F_BUS_ERR  = 2;
    localparam int F_WCLK_ERR = 1;
    localparam int F_PTR_ERR  = 0;

    localparam int NDIR    = 2;
    localparam int DIR_IN  = 0;
    localparam int DIR_OUT = 1;

    typedef enum logic [1:0] {
        ST_OFF       = 2'd0,
        ST_WAIT_NEXT = 2'd1,
        ST_READY     = 2'd2,
        ST_HALT      = 2'd3
    } dir_state_e;

endpackage

// File: rtl/dma_dir_ctrl.sv
module dma_dir_ctrl
    import aud_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          stop_i,
    input  logic          nxt_we_i,
    input  logic [AW-1:0] nxt_wdata_i,
    input  logic          acc_valid_i,
    input  logic          acc_half_i,
    input  logic          buf_end_i,
    input  logic          late_i,
    output logic [AW-1:0] nxt_q_o,
    output logic [AW-1:0] cur_q_o,
    output logic          active_o,
    output logic          done_set_o,
    output logic          ptr_err_o,
    output logic          bus_err_o
);

    localparam logic [AW-1:0] STEP_BYTE = AW'(1);
    localparam logic [AW-1:0] STEP_HALF = AW'(2);

    dir_state_e state_q, state_d;
    logic       load_cur, clr_nxt, clr_cur, advance;
    logic [AW-1:0] nxt_q, cur_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d    = state_q;
        load_cur   = 1'b0;
        clr_nxt    = 1'b0;
        clr_cur    = 1'b0;
        advance    = 1'b0;
        done_set_o = 1'b0;
        ptr_err_o  = 1'b0;
        bus_err_o  = 1'b0;
        active_o   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
            end
            ST_WAIT_NEXT: begin
                active_o  = 1'b1;
                bus_err_o = late_i;
                if (buf_end_i) begin
                    ptr_err_o = 1'b1;
                    state_d   = ST_HALT;
                end else begin
                    advance = acc_valid_i;
                    if (nxt_we_i) state_d = ST_READY;
                end
            end
            ST_READY: begin
                active_o  = 1'b1;
                bus_err_o = late_i;
                if (buf_end_i) begin
                    load_cur   = 1'b1;
                    clr_nxt    = 1'b1;
                    done_set_o = 1'b1;
                    state_d    = nxt_we_i ? ST_READY : ST_WAIT_NEXT;
                end else begin
                    advance = acc_valid_i;
                end
            end
            ST_HALT: begin
            end
        endcase
        // Configuration writes override the per-state behaviour.
        if (stop_i) begin
            state_d    = ST_OFF;
            clr_cur    = 1'b1;
            load_cur   = 1'b0;
            clr_nxt    = 1'b0;
            advance    = 1'b0;
            done_set_o = 1'b0;
            ptr_err_o  = 1'b0;
        end else if (init_i) begin
            state_d    = nxt_we_i ? ST_READY : ST_WAIT_NEXT;
            load_cur   = 1'b1;
            clr_nxt    = 1'b1;
            advance    = 1'b0;
            done_set_o = 1'b0;
            ptr_err_o  = 1'b0;
        end
    end

    // Pointer registers: a write wins over the consume-clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_q <= '0;
        end else if (nxt_we_i) begin
            nxt_q <= nxt_wdata_i;
        end else if (clr_nxt) begin
            nxt_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (clr_cur) begin
            cur_q <= '0;
        end else if (load_cur) begin
            cur_q <= nxt_q;
        end else if (advance) begin
            cur_q <= cur_q + (acc_half_i ? STEP_HALF : STEP_BYTE);
        end
    end

    assign nxt_q_o = nxt_q;
    assign cur_q_o = cur_q;

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
    parameter bit HAS_AUTO = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set_i,
    input  logic auto_clr_i,
    input  logic sw_set_i,
    input  logic sw_clr_i,
    output logic q_o
);

    logic ac;
    logic q_d;

    assign ac = HAS_AUTO ? auto_clr_i : 1'b0;

    // Priority: auto clear, hardware set, software clear, software set.
    always_comb begin
        if (ac)            q_d = 1'b0;
        else if (hw_set_i) q_d = 1'b1;
        else if (sw_clr_i) q_d = 1'b0;
        else if (sw_set_i) q_d = 1'b1;
        else               q_d = q_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= q_d;
    end

endmodule

// File: rtl/aud_dma_ptr_unit.sv
module aud_dma_ptr_unit
    import aud_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_len_we,
    input  logic [LW-1:0]    cfg_len_wdata,
    input  logic             in_nxt_we,
    input  logic [AW-1:0]    in_nxt_wdata,
    input  logic             out_nxt_we,
    input  logic [AW-1:0]    out_nxt_wdata,
    input  logic             in_acc_valid,
    input  logic             in_acc_half,
    input  logic             in_buf_end,
    input  logic             in_acc_late,
    input  logic             out_acc_valid,
    input  logic             out_acc_half,
    input  logic             out_buf_end,
    input  logic             out_acc_late,
    input  logic             wclk_timeout_evt,
    input  logic             wclk_err_evt,
    input  logic             irq_mask_we,
    input  logic [5:0]       irq_mask_wdata,
    input  logic             irq_set_we,
    input  logic [5:0]       irq_set_wdata,
    input  logic             irq_clr_we,
    input  logic [5:0]       irq_clr_wdata,
    output logic [LW-1:0]    buf_len,
    output logic             unit_en,
    output logic [AW-1:0]    in_nxt_rd,
    output logic [AW-1:0]    in_cur,
    output logic             in_active,
    output logic [AW-1:0]    out_nxt_rd,
    output logic [AW-1:0]    out_cur,
    output logic             out_active,
    output logic [5:0]       irq_flags,
    output logic             irq_out
);

    logic [LW-1:0]    len_q;
    logic [NFLAG-1:0] mask_q;
    logic             init_p, stop_p;

    assign init_p = cfg_len_we && (cfg_len_wdata != '0);
    assign stop_p = cfg_len_we && (cfg_len_wdata == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          len_q <= '0;
        else if (cfg_len_we) len_q <= cfg_len_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           mask_q <= '0;
        else if (irq_mask_we) mask_q <= irq_mask_wdata;
    end

    // Per-direction controllers
    logic [NDIR-1:0] d_we, d_valid, d_half, d_end, d_late;
    logic [NDIR-1:0] d_active, d_done, d_perr, d_berr;
    logic [AW-1:0]   d_wdata [NDIR];
    logic [AW-1:0]   d_nxt   [NDIR];
    logic [AW-1:0]   d_cur   [NDIR];

    assign d_we[DIR_IN]     = in_nxt_we;
    assign d_we[DIR_OUT]    = out_nxt_we;
    assign d_valid[DIR_IN]  = in_acc_valid;
    assign d_valid[DIR_OUT] = out_acc_valid;
    assign d_half[DIR_IN]   = in_acc_half;
    assign d_half[DIR_OUT]  = out_acc_half;
    assign d_end[DIR_IN]    = in_buf_end;
    assign d_end[DIR_OUT]   = out_buf_end;
    assign d_late[DIR_IN]   = in_acc_late;
    assign d_late[DIR_OUT]  = out_acc_late;
    assign d_wdata[DIR_IN]  = in_nxt_wdata;
    assign d_wdata[DIR_OUT] = out_nxt_wdata;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        dma_dir_ctrl #(.AW(AW)) u_dir (
            .clk        (clk),
            .rst_n      (rst_n),
            .init_i     (init_p),
            .stop_i     (stop_p),
            .nxt_we_i   (d_we[d]),
            .nxt_wdata_i(d_wdata[d]),
            .acc_valid_i(d_valid[d]),
            .acc_half_i (d_half[d]),
            .buf_end_i  (d_end[d]),
            .late_i     (d_late[d]),
            .nxt_q_o    (d_nxt[d]),
            .cur_q_o    (d_cur[d]),
            .active_o   (d_active[d]),
            .done_set_o (d_done[d]),
            .ptr_err_o  (d_perr[d]),
            .bus_err_o  (d_berr[d])
        );
    end

    // Flag sources
    logic [NFLAG-1:0] hw_set, auto_clr, sw_set, sw_clr, flag_q;

    always_comb begin
        hw_set             = '0;
        hw_set[F_IN_DONE]  = d_done[DIR_IN];
        hw_set[F_OUT_DONE] = d_done[DIR_OUT];
        hw_set[F_WCLK_TO]  = wclk_timeout_evt;
        hw_set[F_BUS_ERR]  = |d_berr;
        hw_set[F_WCLK_ERR] = wclk_err_evt;
        hw_set[F_PTR_ERR]  = |d_perr;
        auto_clr             = '0;
        auto_clr[F_IN_DONE]  = in_nxt_we;
        auto_clr[F_OUT_DONE] = out_nxt_we;
    end

    assign sw_set = irq_set_we ? irq_set_wdata : '0;
    assign sw_clr = irq_clr_we ? irq_clr_wdata : '0;

    for (genvar b = 0; b < NFLAG; b++) begin : g_flag
        irq_flag_cell #(
            .HAS_AUTO((b == F_IN_DONE) || (b == F_OUT_DONE))
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .hw_set_i  (hw_set[b]),
            .auto_clr_i(auto_clr[b]),
            .sw_set_i  (sw_set[b]),
            .sw_clr_i  (sw_clr[b]),
            .q_o       (flag_q[b])
        );
    end

    assign buf_len    = len_q;
    assign unit_en    = (len_q != '0);
    assign in_nxt_rd  = d_nxt[DIR_IN];
    assign in_cur     = d_cur[DIR_IN];
    assign in_active  = d_active[DIR_IN];
    assign out_nxt_rd = d_nxt[DIR_OUT];
    assign out_cur    = d_cur[DIR_OUT];
    assign out_active = d_active[DIR_OUT];
    assign irq_flags  = flag_q;
    assign irq_out    = |(flag_q & mask_q);

endmodule

// File: rtl/aud_dma_ptr_unit_chk.sv
module aud_dma_ptr_unit_chk #(
    parameter int AW = 32,
    parameter int LW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_len_we,
    input logic [LW-1:0] cfg_len_wdata,
    input logic          in_nxt_we,
    input logic          out_nxt_we,
    input logic          in_acc_valid,
    input logic          in_acc_half,
    input logic          in_buf_end,
    input logic          unit_en,
    input logic [AW-1:0] in_cur,
    input logic [AW-1:0] in_nxt_rd,
    input logic          in_active,
    input logic [5:0]    irq_flags,
    input logic          irq_clr_we,
    input logic [5:0]    irq_clr_wdata,
    input logic          irq_out
);

    // R2: current pointer is zero whenever the unit is off
    p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |-> (in_cur == '0));

    // R2: a zero length write clears the current pointer
    p_stop_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_len_we && (cfg_len_wdata == '0)) |=> (in_cur == '0));

    // R3: a buffer end on a running direction leaves the next slot empty
    p_nxt_consumed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_active && in_buf_end && !in_nxt_we && !cfg_len_we) |=> (in_nxt_rd == '0));

    // R4: a halted direction keeps its current pointer
    p_halt_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_en && !in_active && !cfg_len_we) |=> $stable(in_cur));

    // R5: access advances the pointer by its size
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_active && in_acc_valid && !in_buf_end && !cfg_len_we) |=>
        (in_cur == $past(in_cur) + ($past(in_acc_half) ? AW'(2) : AW'(1))));

    // R6: a next-pointer write always leaves the done flag clear
    p_autoclr_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_nxt_we |=> !irq_flags[5]);
    p_autoclr_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_nxt_we |=> !irq_flags[4]);

    // R7: error and event flags stay set without a clear
    for (genvar b = 0; b < 4; b++) begin : g_sticky
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flags[b] && !(irq_clr_we && irq_clr_wdata[b])) |=> irq_flags[b]);
    end

    // R9: no flag, no interrupt
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags == '0) |-> !irq_out);

endmodule

bind aud_dma_ptr_unit aud_dma_ptr_unit_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_len_we   (cfg_len_we),
    .cfg_len_wdata(cfg_len_wdata),
    .in_nxt_we    (in_nxt_we),
    .out_nxt_we   (out_nxt_we),
    .in_acc_valid (in_acc_valid),
    .in_acc_half  (in_acc_half),
    .in_buf_end   (in_buf_end),
    .unit_en      (unit_en),
    .in_cur       (in_cur),
    .in_nxt_rd    (in_nxt_rd),
    .in_active    (in_active),
    .irq_flags    (irq_flags),
    .irq_clr_we   (irq_clr_we),
    .irq_clr_wdata(irq_clr_wdata),
    .irq_out      (irq_out)
);

// File: tb/aud_dma_ptr_unit_test.sv
module aud_dma_ptr_unit_test;

    localparam int AW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_len_we = 0;
    logic [LW-1:0] cfg_len_wdata = '0;
    logic          in_nxt_we = 0, out_nxt_we = 0;
    logic [AW-1:0] in_nxt_wdata = '0, out_nxt_wdata = '0;
    logic          in_acc_valid = 0, in_acc_half = 0, in_buf_end = 0, in_acc_late = 0;
    logic          out_acc_valid = 0, out_acc_half = 0, out_buf_end = 0, out_acc_late = 0;
    logic          wclk_timeout_evt = 0, wclk_err_evt = 0;
    logic          irq_mask_we = 0, irq_set_we = 0, irq_clr_we = 0;
    logic [5:0]    irq_mask_wdata = '0, irq_set_wdata = '0, irq_clr_wdata = '0;
    logic [LW-1:0] buf_len;
    logic          unit_en, in_active, out_active, irq_out;
    logic [AW-1:0] in_nxt_rd, in_cur, out_nxt_rd, out_cur;
    logic [5:0]    irq_flags;

    int total = 0;
    int fails = 0;
    logic [AW-1:0] e_in, e_out;
    logic [5:0]    f_before;

    always #2 clk = ~clk;

    aud_dma_ptr_unit #(.AW(AW), .LW(LW)) uut (.*);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_len_we = 0; in_nxt_we = 0; out_nxt_we = 0;
        in_acc_valid = 0; in_acc_half = 0; in_buf_end = 0; in_acc_late = 0;
        out_acc_valid = 0; out_acc_half = 0; out_buf_end = 0; out_acc_late = 0;
        wclk_timeout_evt = 0; wclk_err_evt = 0;
        irq_mask_we = 0; irq_set_we = 0; irq_clr_we = 0;
        irq_set_wdata = '0; irq_clr_wdata = '0;
    endtask

    function automatic logic exp_flag(input logic f, input logic hw,
                                      input logic ss, input logic sc);
        if (hw)      return 1'b1;
        else if (sc) return 1'b0;
        else if (ss) return 1'b1;
        else         return f;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "flags", irq_flags, 0);
        check("R1", "in_cur", in_cur, 0);
        check("R1", "out_nxt", out_nxt_rd, 0);
        check("R1", "irq", irq_out, 0);
        rst_n = 1'b1;
        step();
        check("R1", "unit_en", unit_en, 0);
        check("R1", "actives", {in_active, out_active}, 0);
        check("R1", "buf_len", buf_len, 0);

        // R2 off: ends and accesses do nothing
        in_buf_end = 1; in_acc_valid = 1; step(); idle();
        check("R2", "off end flags", irq_flags, 0);
        check("R2", "off access", in_cur, 0);

        // Preload and enable
        in_nxt_we = 1; in_nxt_wdata = 32'h1000;
        out_nxt_we = 1; out_nxt_wdata = 32'h2000; step(); idle();
        check("R3", "in readback", in_nxt_rd, 32'h1000);
        check("R3", "out readback", out_nxt_rd, 32'h2000);
        cfg_len_we = 1; cfg_len_wdata = 8'd4; step(); idle();
        check("R2", "in_cur init", in_cur, 32'h1000);
        check("R2", "out_cur init", out_cur, 32'h2000);
        check("R2", "nxt zero", {in_nxt_rd, out_nxt_rd}, 0);
        check("R2", "active", {in_active, out_active}, 2'b11);
        check("R2", "len", {unit_en, buf_len}, {1'b1, 8'd4});
        check("R2", "no flag", irq_flags, 0);

        // R5 access sweep
        e_in = 32'h1000; e_out = 32'h2000;
        for (int i = 0; i < 24; i++) begin
            in_acc_valid  = (i % 3) != 0;
            in_acc_half   = i[0];
            out_acc_valid = (i % 4) != 1;
            out_acc_half  = i[1];
            step();
            if (in_acc_valid)  e_in  = e_in  + (in_acc_half  ? 2 : 1);
            if (out_acc_valid) e_out = e_out + (out_acc_half ? 2 : 1);
            check("R5", "in advance", in_cur, e_in);
            check("R5", "out advance", out_cur, e_out);
        end
        idle();

        // R3 handover
        in_nxt_we = 1; in_nxt_wdata = 32'h3000; step(); idle();
        check("R3", "readback before end", in_nxt_rd, 32'h3000);
        in_buf_end = 1; in_acc_valid = 1; step(); idle();
        check("R3", "in handover", in_cur, 32'h3000);
        check("R5", "access dropped at end", in_cur, 32'h3000);
        check("R3", "in nxt zero", in_nxt_rd, 0);
        check("R3", "in done bit5", irq_flags[5], 1);
        out_nxt_we = 1; out_nxt_wdata = 32'h4000; step(); idle();
        out_buf_end = 1; step(); idle();
        check("R3", "out handover", out_cur, 32'h4000);
        check("R3", "out done bit4", irq_flags[4], 1);
        e_out = 32'h4000;

        // R6 auto clear vs software set and handover
        in_nxt_we = 1; in_nxt_wdata = 32'h5000;
        irq_set_we = 1; irq_set_wdata = 6'h20; step(); idle();
        check("R6", "autoclr beats sw set", irq_flags[5], 0);
        irq_set_we = 1; irq_set_wdata = 6'h20; step(); idle();
        check("R8", "sw set bit5", irq_flags[5], 1);
        in_nxt_we = 1; in_nxt_wdata = 32'h6000; in_buf_end = 1; step(); idle();
        check("R6", "old ptr handed over", in_cur, 32'h5000);
        check("R6", "new ptr kept", in_nxt_rd, 32'h6000);
        check("R6", "autoclr beats done", irq_flags[5], 0);
        check("R6", "still running", in_active, 1);

        // R7/R8 exhaustive on bits 3 and 1
        for (int k = 0; k < 2; k++) begin
            int b;
            b = (k == 0) ? 3 : 1;
            for (int c = 0; c < 16; c++) begin
                logic f0, hw, ss, sc;
                f0 = c[0]; hw = c[1]; ss = c[2]; sc = c[3];
                if (f0) begin irq_set_we = 1; irq_set_wdata = 6'(1 << b); end
                else    begin irq_clr_we = 1; irq_clr_wdata = 6'(1 << b); end
                step(); idle();
                irq_set_we = 1; irq_set_wdata = ss ? 6'(1 << b) : 6'h0;
                irq_clr_we = 1; irq_clr_wdata = sc ? 6'(1 << b) : 6'h0;
                if (b == 3) wclk_timeout_evt = hw; else wclk_err_evt = hw;
                step(); idle();
                check(hw ? "R7" : "R8", $sformatf("bit%0d combo%0d", b, c),
                      irq_flags[b], exp_flag(f0, hw, ss, sc));
            end
        end
        wclk_timeout_evt = 1; step(); idle();
        step();
        check("R7", "bit3 sticky", irq_flags[3], 1);

        // Bus error (bit2) on running input direction
        in_acc_late = 1; step(); idle();
        check("R7", "late sets bit2", irq_flags[2], 1);
        in_acc_late = 1; irq_clr_we = 1; irq_clr_wdata = 6'h04; step(); idle();
        check("R8", "clear ignored on set", irq_flags[2], 1);
        irq_clr_we = 1; irq_clr_wdata = 6'h04; step(); idle();
        check("R8", "clear bit2", irq_flags[2], 0);

        // R9 mask sweep with flags 6'h15
        irq_clr_we = 1; irq_clr_wdata = 6'h3f; step(); idle();
        irq_set_we = 1; irq_set_wdata = 6'h15; step(); idle();
        check("R8", "pattern set", irq_flags, 6'h15);
        for (int m = 0; m < 64; m++) begin
            irq_mask_we = 1; irq_mask_wdata = 6'(m); step(); idle();
            check("R9", $sformatf("mask %0h", m), irq_out, (6'(m) & 6'h15) != 0);
        end
        irq_clr_we = 1; irq_clr_wdata = 6'h3f; step(); idle();
        check("R9", "all masked in, no flags", irq_out, 0);

        // R4 input underrun
        in_buf_end = 1; step(); idle();
        check("R3", "handover 6000", in_cur, 32'h6000);
        in_buf_end = 1; step(); idle();
        check("R4", "ptr err", irq_flags[0], 1);
        check("R4", "in halted", in_active, 0);
        check("R4", "cur frozen", in_cur, 32'h6000);
        in_acc_valid = 1; in_acc_half = 1; step(); idle();
        check("R4", "access ignored", in_cur, 32'h6000);
        in_acc_late = 1; in_buf_end = 1; step(); idle();
        check("R4", "late ignored", irq_flags[2], 0);
        check("R4", "end ignored", in_cur, 32'h6000);
        check("R4", "out still active", out_active, 1);

        // R4 output: write in same cycle as end is late
        irq_clr_we = 1; irq_clr_wdata = 6'h01; step(); idle();
        check("R8", "clear bit0", irq_flags[0], 0);
        out_nxt_we = 1; out_nxt_wdata = 32'h7000; out_buf_end = 1; step(); idle();
        check("R4", "out ptr err", irq_flags[0], 1);
        check("R4", "out halted", out_active, 0);
        check("R4", "out cur frozen", out_cur, e_out);
        step();
        check("R7", "bit0 sticky", irq_flags[0], 1);

        // R2 stop
        f_before = irq_flags;
        cfg_len_we = 1; cfg_len_wdata = 8'd0; step(); idle();
        check("R2", "stop cur", {in_cur, out_cur}, 0);
        check("R2", "stop inactive", {unit_en, in_active, out_active}, 0);
        check("R2", "stop flags kept", irq_flags, f_before);
        in_acc_valid = 1; in_buf_end = 1; step(); idle();
        check("R5", "no access when off", in_cur, 0);
        check("R2", "no flag when off", irq_flags, f_before);

        // Re-enable from halt
        in_nxt_we = 1; in_nxt_wdata = 32'h8000;
        out_nxt_we = 1; out_nxt_wdata = 32'h9000; step(); idle();
        cfg_len_we = 1; cfg_len_wdata = 8'd2; step(); idle();
        check("R2", "reinit in", in_cur, 32'h8000);
        check("R2", "reinit out", out_cur, 32'h9000);
        check("R2", "reinit active", {in_active, out_active}, 2'b11);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule